// File: doc/BRIEF.md
# Multi-Lane Pipelined Vector Multiplier

The block executes one element-wise vector multiply at a time. The destination vector receives, for each element, the product of the matching elements of two source vectors. A start strobe captures three register numbers (two sources and one destination), an element count and a per-element write mask. The elements are dealt out to `LANES` parallel lanes in interleaved order, so element `i` is handled by lane `i mod LANES`. One group of `LANES` elements is issued every clock until the count runs out. Each lane holds a fixed six-stage multiplier pipeline that never stalls, because no element depends on another. Integer multiplication stands in for floating point, and only the low `DW` bits of each product are kept.

The source and destination register files sit outside the block. Each one is banked by lane, so a single row address serves all lanes of a group.
- **Reads.** The block presents a read strobe with two row addresses and expects the operand words of every lane on the next cycle, as a synchronous RAM with one cycle of read latency would supply them.
- **Writes.** The block drives one write-enable bit per lane, a shared row address and the packed result words.
- **Suppressed elements.** Elements past the count, and elements whose mask bit is clear, produce no write, so the destination keeps its old contents.
- **Completion.** A one-cycle `done` pulse marks the end of an operation.

Top module: `vlane_mul`

## Requirements
- R1: While reset is applied and in the cycle after it, `rd_en`, `wr_en` and `done` are all low.
- R2: Element `i` is written by lane `i mod LANES`. That lane drives bit `l` of `wr_en` and the slice `wr_data[l*DW +: DW]`. `wr_addr` is `{vd, i/LANES}`: the destination register number sits in the upper `RW` bits and the group index in the low `GW` bits.
- R3: Each written word equals the low `DW` bits of the product of the operand words that the two sources supplied for that element.
- R4: One group is issued per cycle with no stall. Take the clock edge that accepts `start` as edge 0. The read for group `g` is visible after edge `1+g`. The write for group `g` is visible after edge `8+g`, which is six edges after its operands are presented.
- R5: Elements whose index is at or above the captured length are never written. A length above `VLMAX` is treated as `VLMAX`.
- R6: Bit `i` of `mask` controls element `i`: 1 writes the element, 0 suppresses its write.
- R7: A length of zero causes no read and no write. It raises `done` right after edge 0.
- R8: `done` is a single-cycle pulse in the cycle that follows the write cycle of the last group. No write occurs while `done` is high.
- R9: A `start` that arrives while an operation is in progress is ignored and leads to no read and no write.
- R10: `rd_en` is high for exactly the issued groups. For group `g`, `rd_addr1` is `{vs1, g}` and `rd_addr2` is `{vs2, g}`. The operand words are taken from `src1_data` and `src2_data` in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vs1 | input | RW | First source register number |
| vs2 | input | RW | Second source register number |
| vd | input | RW | Destination register number |
| vl | input | VLW | Element count, 0 to VLMAX (larger values are clamped) |
| mask | input | VLMAX | Per-element write mask, bit i for element i |
| rd_en | output | 1 | Source read strobe for one group |
| rd_addr1 | output | AW | First source row `{vs1, group}` |
| rd_addr2 | output | AW | Second source row `{vs2, group}` |
| src1_data | input | LANES*DW | First source words, lane l at `[l*DW +: DW]` |
| src2_data | input | LANES*DW | Second source words, lane l at `[l*DW +: DW]` |
| wr_en | output | LANES | Per-lane destination write enable |
| wr_addr | output | AW | Destination row `{vd, group}` |
| wr_data | output | LANES*DW | Results, lane l at `[l*DW +: DW]` |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the block with its defaults: four lanes, 64 elements, eight registers and 64-bit words, which gives sixteen groups per register. With these values a length that is not a multiple of four leaves the last group only partly filled. A length of 100 exercises the clamp to 64, and source words near all-ones make the high product bits fall away. A queue-free, cycle-indexed model predicts the read strobe, the write enables, the addresses, the data and `done` for every cycle, including a second `start` that arrives during a run.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  // fixed depth of every lane multiplier
  localparam int MUL_STAGES = 6;
  // cycles between a read strobe and its operand words
  localparam int RD_LAT     = 1;
  // issue register to lane output
  localparam int PIPE_DEPTH = RD_LAT + MUL_STAGES;
endpackage

// File: rtl/vmul_delay.sv
module vmul_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [D];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < D; k++) sr[k] <= '0;
    end else begin
      sr[0] <= d;
      for (int k = 1; k < D; k++) sr[k] <= sr[k-1];
    end
  end

  assign q = sr[D-1];
endmodule

// File: rtl/vmul_lane.sv
module vmul_lane
  import vmul_pkg::*;
#(
  parameter  int DW = 64,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_we,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          out_we,
  output logic [DW-1:0] out_p
);
  localparam int TAIL = MUL_STAGES - 3;

  logic [DW-1:0]         a1, b1, plo, p3;
  logic [HW-1:0]         phi;
  logic [DW-1:0]         tail [TAIL];
  logic [MUL_STAGES-1:0] we_sr;

  // write-enable travels beside the data; the only reset state
  always_ff @(posedge clk) begin
    if (rst) we_sr <= '0;
    else     we_sr <= {we_sr[MUL_STAGES-2:0], in_we};
  end

  // s1 operands, s2 partial products, s3 sum, s4..s6 retiming
  always_ff @(posedge clk) begin
    a1  <= op_a;
    b1  <= op_b;
    plo <= {{HW{1'b0}}, a1[HW-1:0]} * b1;
    phi <= a1[DW-1:HW] * b1[HW-1:0];
    p3  <= plo + {phi, {HW{1'b0}}};
    tail[0] <= p3;
    for (int k = 1; k < TAIL; k++) tail[k] <= tail[k-1];
  end

  assign out_p  = tail[TAIL-1];
  assign out_we = we_sr[MUL_STAGES-1];

  // R3
  lane_prod_chk: assert property (@(posedge clk) disable iff (rst)
    out_we |-> out_p == ($past(a1, 5) * $past(b1, 5)));
endmodule

// File: rtl/vmul_seq.sv
module vmul_seq #(
  parameter  int LANES = 4,
  parameter  int VLMAX = 64,
  parameter  int NREG  = 8,
  localparam int LW    = $clog2(LANES),
  localparam int GRPS  = VLMAX / LANES,
  localparam int GW    = $clog2(GRPS),
  localparam int IW    = $clog2(VLMAX),
  localparam int VLW   = IW + 1,
  localparam int RW    = $clog2(NREG),
  localparam int AW    = RW + GW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [RW-1:0]    vs1,
  input  logic [RW-1:0]    vs2,
  input  logic [RW-1:0]    vd,
  input  logic [VLW-1:0]   vl,
  input  logic [VLMAX-1:0] mask,
  input  logic             last_out,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr1,
  output logic [AW-1:0]    rd_addr2,
  output logic [GW-1:0]    iss_grp,
  output logic [LANES-1:0] iss_we,
  output logic             iss_last,
  output logic [RW-1:0]    vd_q,
  output logic [VLW-1:0]   vl_q,
  output logic             busy,
  output logic             done
);
  logic             issuing, acc, grp_last;
  logic [GW-1:0]    nxt_grp;
  logic [VLMAX-1:0] mask_q;
  logic [RW-1:0]    vs1_q, vs2_q;
  logic [VLW-1:0]   vl_clamp;
  logic [LANES-1:0] lane_we;

  assign acc      = start && !busy;
  assign vl_clamp = (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;
  assign grp_last = ({1'b0, nxt_grp, {LW{1'b1}}} + VLW'(1)) >= vl_q;

  // interleaved dealing: lane l takes element nxt_grp*LANES + l
  for (genvar l = 0; l < LANES; l++) begin : g_we
    logic [IW-1:0] eidx;
    assign eidx       = {nxt_grp, LW'(l)};
    assign lane_we[l] = issuing && ({1'b0, eidx} < vl_q) && mask_q[eidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; issuing <= 1'b0; done <= 1'b0;
      rd_en <= 1'b0; iss_we <= '0; iss_last <= 1'b0;
      nxt_grp <= '0; iss_grp <= '0;
      vl_q <= '0; mask_q <= '0; vs1_q <= '0; vs2_q <= '0; vd_q <= '0;
    end else begin
      done     <= (acc && vl_clamp == '0) || last_out;
      rd_en    <= issuing;
      iss_we   <= lane_we;
      iss_last <= issuing && grp_last;
      iss_grp  <= nxt_grp;
      if (acc) begin
        vl_q    <= vl_clamp;
        mask_q  <= mask;
        vs1_q   <= vs1;
        vs2_q   <= vs2;
        vd_q    <= vd;
        busy    <= vl_clamp != '0;
        issuing <= vl_clamp != '0;
        nxt_grp <= '0;
      end else if (last_out) begin
        busy <= 1'b0;
      end
      if (issuing) begin
        nxt_grp <= nxt_grp + GW'(1);
        if (grp_last) issuing <= 1'b0;
      end
    end
  end

  assign rd_addr1 = {vs1_q, iss_grp};
  assign rd_addr2 = {vs2_q, iss_grp};

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(vl_q) && $stable(mask_q) && $stable(vd_q)));

  // R10
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

// File: rtl/vlane_mul.sv
module vlane_mul
  import vmul_pkg::*;
#(
  parameter  int LANES = 4,
  parameter  int VLMAX = 64,
  parameter  int NREG  = 8,
  parameter  int DW    = 64,
  localparam int LW    = $clog2(LANES),
  localparam int GRPS  = VLMAX / LANES,
  localparam int GW    = $clog2(GRPS),
  localparam int VLW   = $clog2(VLMAX) + 1,
  localparam int RW    = $clog2(NREG),
  localparam int AW    = RW + GW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [RW-1:0]       vs1,
  input  logic [RW-1:0]       vs2,
  input  logic [RW-1:0]       vd,
  input  logic [VLW-1:0]      vl,
  input  logic [VLMAX-1:0]    mask,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr1,
  output logic [AW-1:0]       rd_addr2,
  input  logic [LANES*DW-1:0] src1_data,
  input  logic [LANES*DW-1:0] src2_data,
  output logic [LANES-1:0]    wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [LANES*DW-1:0] wr_data,
  output logic                done
);
  logic [GW-1:0]    iss_grp, grp_out;
  logic [LANES-1:0] iss_we, lane_in_we;
  logic             iss_last, last_out, busy;
  logic [RW-1:0]    vd_q;
  logic [VLW-1:0]   vl_q;

  vmul_seq #(.LANES(LANES), .VLMAX(VLMAX), .NREG(NREG)) u_seq (
    .clk(clk), .rst(rst), .start(start), .vs1(vs1), .vs2(vs2), .vd(vd),
    .vl(vl), .mask(mask), .last_out(last_out),
    .rd_en(rd_en), .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
    .iss_grp(iss_grp), .iss_we(iss_we), .iss_last(iss_last),
    .vd_q(vd_q), .vl_q(vl_q), .busy(busy), .done(done)
  );

  // enables wait for the read latency before meeting their operands
  vmul_delay #(.W(LANES), .D(RD_LAT)) u_we_dly (
    .clk(clk), .rst(rst), .d(iss_we), .q(lane_in_we)
  );

  // group index and last flag ride the whole path to the output
  vmul_delay #(.W(GW + 1), .D(PIPE_DEPTH)) u_ctl_dly (
    .clk(clk), .rst(rst), .d({iss_grp, iss_last}), .q({grp_out, last_out})
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vmul_lane #(.DW(DW)) u_lane (
      .clk(clk), .rst(rst), .in_we(lane_in_we[l]),
      .op_a(src1_data[l*DW +: DW]), .op_b(src2_data[l*DW +: DW]),
      .out_we(wr_en[l]), .out_p(wr_data[l*DW +: DW])
    );

    // R5
    in_len_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en[l] |-> ({1'b0, grp_out, LW'(l)} < vl_q));
  end

  assign wr_addr = {vd_q, grp_out};

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl == '0) |=> (done && !rd_en && wr_en == '0));

  // R8
  done_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_en == '0 && !busy));
endmodule

// File: tb/vlane_mul_bench.sv
module vlane_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4, VLMAX = 64, NREG = 8, DW = 64;
  localparam int GRPS = VLMAX / LANES, GW = 4, RW = 3, AW = 7, VLW = 7;
  localparam int MAXC = 4096;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [RW-1:0] vs1 = '0, vs2 = '0, vd = '0;
  logic [VLW-1:0] vl = '0;
  logic [VLMAX-1:0] mask = '0;
  logic rd_en, done;
  logic [AW-1:0] rd_addr1, rd_addr2, wr_addr;
  logic [LANES*DW-1:0] src1_data, src2_data, wr_data;
  logic [LANES-1:0] wr_en;

  int cyc = 0, checks = 0, fails = 0, stray = 0;
  bit chk_on = 0, finished = 0;

  logic [DW-1:0] mem [LANES][NREG*GRPS];
  logic [DW-1:0] q1 [LANES];
  logic [DW-1:0] q2 [LANES];

  logic             exp_rd   [MAXC];
  logic [AW-1:0]    exp_ra1  [MAXC];
  logic [AW-1:0]    exp_ra2  [MAXC];
  logic [LANES-1:0] exp_en   [MAXC];
  logic [AW-1:0]    exp_wa   [MAXC];
  logic [DW-1:0]    exp_dat  [MAXC][LANES];
  logic             exp_done [MAXC];

  vlane_mul u_vlane_mul (
    .clk(clk), .rst(rst), .start(start), .vs1(vs1), .vs2(vs2), .vd(vd),
    .vl(vl), .mask(mask), .rd_en(rd_en), .rd_addr1(rd_addr1),
    .rd_addr2(rd_addr2), .src1_data(src1_data), .src2_data(src2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // source register file: banked by lane, one cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      for (int l = 0; l < LANES; l++) begin
        q1[l] <= mem[l][rd_addr1];
        q2[l] <= mem[l][rd_addr2];
      end
    end
  end
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      src1_data[l*DW +: DW] = q1[l];
      src2_data[l*DW +: DW] = q2[l];
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    finished = 1;
    $finish;
  endtask

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", what, cyc, act, exp);
    end
  endtask

  // compare every cycle against the model tables
  always @(negedge clk) begin
    if (chk_on && !finished) begin
      chk(rd_en === exp_rd[cyc], "R4 R10 rd_en", 64'(rd_en), 64'(exp_rd[cyc]));
      if (exp_rd[cyc]) begin
        chk(rd_addr1 === exp_ra1[cyc], "R10 rd_addr1", 64'(rd_addr1), 64'(exp_ra1[cyc]));
        chk(rd_addr2 === exp_ra2[cyc], "R10 rd_addr2", 64'(rd_addr2), 64'(exp_ra2[cyc]));
      end
      chk(wr_en === exp_en[cyc], "R4 R5 R6 wr_en", 64'(wr_en), 64'(exp_en[cyc]));
      if (exp_en[cyc] != '0)
        chk(wr_addr === exp_wa[cyc], "R2 wr_addr", 64'(wr_addr), 64'(exp_wa[cyc]));
      for (int l = 0; l < LANES; l++)
        if (exp_en[cyc][l])
          chk(wr_data[l*DW +: DW] === exp_dat[cyc][l], "R3 wr_data",
              wr_data[l*DW +: DW], exp_dat[cyc][l]);
      chk(done === exp_done[cyc], "R7 R8 done", 64'(done), 64'(exp_done[cyc]));
      if (wr_en != '0 && wr_addr[AW-1:GW] == 3'd7) stray++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: cycle %0d actual no completion expected end before 20000", cyc);
      report();
    end
  end

  task automatic run_op(input int s1, input int s2, input int d, input int len,
                        input logic [VLMAX-1:0] m, input bit busy_start);
    int c0, vlc, ng;
    @(negedge clk);
    c0  = cyc + 1;
    vlc = (len > VLMAX) ? VLMAX : len;
    ng  = (vlc + LANES - 1) / LANES;
    start = 1'b1; vs1 = RW'(s1); vs2 = RW'(s2); vd = RW'(d); vl = VLW'(len); mask = m;
    if (vlc == 0) exp_done[c0] = 1'b1;
    else begin
      for (int g = 0; g < ng; g++) begin
        exp_rd[c0+1+g]  = 1'b1;
        exp_ra1[c0+1+g] = AW'(s1*GRPS + g);
        exp_ra2[c0+1+g] = AW'(s2*GRPS + g);
        exp_wa[c0+8+g]  = AW'(d*GRPS + g);
        for (int l = 0; l < LANES; l++) begin
          int i;
          logic [DW-1:0] a, b;
          i = g*LANES + l;
          a = mem[l][s1*GRPS + g];
          b = mem[l][s2*GRPS + g];
          if (i < vlc && m[i]) begin
            exp_en[c0+8+g][l]  = 1'b1;
            exp_dat[c0+8+g][l] = a * b;
          end
        end
      end
      exp_done[c0+8+ng] = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    if (busy_start) begin
      // R9: a second request mid-run, destination register 7
      repeat (2) @(negedge clk);
      start = 1'b1; vs1 = 3'd0; vs2 = 3'd1; vd = 3'd7; vl = 7'd9; mask = '1;
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < c0 + 8 + ng + 2) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < MAXC; c++) begin
      exp_rd[c] = 0; exp_ra1[c] = '0; exp_ra2[c] = '0; exp_en[c] = '0;
      exp_wa[c] = '0; exp_done[c] = 0;
      for (int l = 0; l < LANES; l++) exp_dat[c][l] = '0;
    end
    for (int l = 0; l < LANES; l++) begin
      q1[l] = '0; q2[l] = '0;
      for (int a = 0; a < NREG*GRPS; a++)
        mem[l][a] = {32'(a*32'h9E37_79B9 + l*977), 32'(a*131 + l*32'h85EB_CA6B + 5)};
      for (int g = 0; g < GRPS; g++)
        mem[l][5*GRPS + g] = 64'hFFFF_FFFF_FFFF_FFF0 - 64'(g*LANES + l);
    end
    repeat (2) @(negedge clk);
    // R1: outputs quiet under reset
    chk(rd_en === 1'b0 && wr_en === '0 && done === 1'b0, "R1 reset outputs",
        {wr_en, rd_en, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_en === 1'b0 && wr_en === '0 && done === 1'b0, "R1 after reset",
        {wr_en, rd_en, done}, 64'd0);
    chk_on = 1;

    run_op(1, 2, 3, 64, '1, 0);                    // R2 R3 R4 full length
    run_op(5, 5, 4, 13, '1, 0);                    // R3 truncation, R5 partial group
    run_op(2, 6, 0, 10, 64'hAAAA_AAAA_AAAA_AAAA, 0); // R6 alternating mask
    run_op(1, 1, 2, 0, '1, 0);                     // R7 zero length
    run_op(3, 4, 6, 100, 64'h0F0F_33CC_FFFF_1248, 0); // R5 clamp, R6 mask
    run_op(0, 7, 1, 1, '1, 0);                     // R5 single element
    run_op(4, 5, 2, 4, 64'hE, 0);                  // R6 lane 0 masked
    run_op(6, 2, 5, 24, '1, 1);                    // R9 start while busy
    chk(stray == 0, "R9 writes from ignored start", 64'(stray), 64'd0);
    run_op(7, 1, 0, 0, '0, 0);                     // R7 again, idle after
    repeat (4) @(negedge clk);
    report();
  end
endmodule